// File: doc/BRIEF.md
# Counter-Based Pulse Stretcher

This block turns a one-cycle strobe into an output that stays high for a fixed number of clock cycles. The default is four cycles. A short loadable counter holds the remaining run, so the cost stays at a few flip-flops even when the stretch length grows. A strobe that arrives while the output is already high reloads the counter, so the output then runs for the full length counted from that latest strobe.

A build-time parameter picks one of two implementations:

- **Registered.** The top bit of a counter is both the output and the count enable. The output comes straight from a flip-flop and rises one cycle after the strobe.
- **Low-latency.** A narrower counter is ORed with the live strobe, so the output rises in the same cycle as the strobe. That output is combinational and may glitch. It must be registered again before any further use, and it must never feed a clock or any other edge-sensitive input.

Top module: `pulse_stretch`

## Requirements
- R1: While `rst` is high at a clock edge, the state is cleared and any strobe is ignored. After that edge, the registered output is low, and the low-latency output equals the live strobe.
- R2: In registered mode, a strobe sampled at a clock edge makes `stretched_o` high in the cycle that follows that edge.
- R3: In registered mode, a lone strobe gives exactly LEN consecutive high cycles. These are the LEN cycles after the strobe cycle, and the strobe cycle itself stays low.
- R4: In low-latency mode, `stretched_o` is high in the same cycle in which `strobe_i` is high.
- R5: In low-latency mode, a lone strobe gives exactly LEN consecutive high cycles, counting the strobe cycle as the first.
- R6: A strobe that arrives while the output is high restarts the run. The output stays high without a gap until LEN cycles after that latest strobe.
- R7: A strobe held high for N consecutive cycles gives one unbroken high run of N+LEN-1 cycles. The run starts one cycle later in registered mode than in low-latency mode.
- R8: With no strobe, the output drops when its run ends and stays low; the counter does not start again by itself.
- R9: A reset in the middle of a pulse ends it. From the next cycle the output is low and stays low until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Input strobe; each high cycle starts or restarts a run |
| stretched_o | output | 1 | Widened pulse (registered, or combinational in low-latency mode) |

## Verification
The hardest case to reach from the ports is a retrigger that lands in the middle of a run. The counter must reload on that exact cycle, and the output must run on with no gap and stop at the right cycle. A stimulus table places strobes three cycles apart, and then three strobes back to back. For every cycle, the table gives the expected level in both modes, so an off-by-one at a run's end shows up on a single sampled cycle. Further instances built at lengths 5 and 6 check that the counter width and load value scale with the parameter. A reset applied in mid-run checks that the pulse does not come back afterwards.

// File: rtl/pstr_pkg.sv
`timescale 1ns/1ps
package pstr_pkg;

    typedef enum logic {
        PSTR_REGISTERED = 1'b0,
        PSTR_LOWLAT     = 1'b1
    } pstr_mode_e;

    // Registered form: width such that the top bit alone covers LEN states.
    function automatic int reg_ctr_width(input int len);
        return $clog2(len) + 1;
    endfunction

    // Low-latency form: width that just holds LEN-1.
    function automatic int wrap_ctr_width(input int len);
        return (len < 2) ? 1 : $clog2(len);
    endfunction

    // Width of the run-age trackers used by the checks.
    function automatic int age_width(input int len);
        return $clog2(len + 2);
    endfunction

endpackage

// File: rtl/pstr_load_ctr.sv
`timescale 1ns/1ps
module pstr_load_ctr #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic pulse_o
);
    import pstr_pkg::*;

    localparam int CW       = reg_ctr_width(LEN);
    localparam int LOAD_INT = (1 << CW) - LEN;
    localparam logic [CW-1:0] LOAD = LOAD_INT[CW-1:0];

    logic [CW-1:0] cnt_q;

    // Load places the count LEN steps below the wrap; the top bit stays set
    // for exactly those steps and gates its own advance.
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (strobe_i)
            cnt_q <= LOAD;
        else if (cnt_q[CW-1])
            cnt_q <= cnt_q + 1'b1;
    end

    assign pulse_o = cnt_q[CW-1];

    // Checks: independent age since the last strobe, saturating at LEN+1.
    localparam int AW = age_width(LEN);
    localparam logic [AW-1:0] AGE_IDLE = AW'(LEN + 1);
    localparam logic [AW-1:0] AGE_LAST = AW'(LEN);
    logic [AW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= AGE_IDLE;
        else if (strobe_i)
            age_q <= AW'(1);
        else if (age_q <= AGE_LAST)
            age_q <= age_q + 1'b1;
    end

    p_reset_low_r1: assert property (@(posedge clk)
        rst |=> !pulse_o);

    p_rise_next_r2: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> pulse_o);

    p_len_match_r3: assert property (@(posedge clk) disable iff (rst)
        pulse_o == (age_q <= AGE_LAST));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (!pulse_o && !strobe_i) |=> !pulse_o);

endmodule

// File: rtl/pstr_wrap_ctr.sv
`timescale 1ns/1ps
module pstr_wrap_ctr #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic pulse_o
);
    import pstr_pkg::*;

    localparam int CW = wrap_ctr_width(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    // Zero means idle; a strobe starts at 1 and the count wraps to 0 after LAST.
    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (strobe_i)
            cnt_q <= CW'(1);
        else if (cnt_q != '0)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Combinational: may glitch, must be re-registered by the consumer.
    assign pulse_o = strobe_i | (cnt_q != '0);

    // Checks: cycles since the last strobe, saturating at LEN.
    localparam int AW = age_width(LEN);
    localparam logic [AW-1:0] AGE_LIM = AW'(LEN);
    logic [AW-1:0] age_q;

    always_ff @(posedge clk) begin
        if (rst)
            age_q <= AGE_LIM;
        else if (strobe_i)
            age_q <= AW'(1);
        else if (age_q < AGE_LIM)
            age_q <= age_q + 1'b1;
    end

    p_reset_follow_r1: assert property (@(posedge clk)
        rst |=> (pulse_o == strobe_i));

    p_hold_next_r4: assert property (@(posedge clk) disable iff (rst)
        strobe_i |=> pulse_o);

    p_len_match_r5: assert property (@(posedge clk) disable iff (rst)
        pulse_o == (strobe_i || (age_q < AGE_LIM)));

    p_ctr_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/pulse_stretch.sv
`timescale 1ns/1ps
module pulse_stretch #(
    parameter int                   LEN  = 4,
    parameter pstr_pkg::pstr_mode_e MODE = pstr_pkg::PSTR_REGISTERED
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic stretched_o
);
    import pstr_pkg::*;

    initial assert (LEN >= 2) else $error("pulse_stretch: LEN must be at least 2");

    generate
        if (MODE == PSTR_REGISTERED) begin : g_reg
            pstr_load_ctr #(.LEN(LEN)) u_ctr (
                .clk      (clk),
                .rst      (rst),
                .strobe_i (strobe_i),
                .pulse_o  (stretched_o)
            );
        end else begin : g_fast
            pstr_wrap_ctr #(.LEN(LEN)) u_ctr (
                .clk      (clk),
                .rst      (rst),
                .strobe_i (strobe_i),
                .pulse_o  (stretched_o)
            );
        end
    endgenerate

    // R6 retrigger: after a strobe the output is high on the next cycle in both forms.
    p_retrig_r6: assert property (@(posedge clk) disable iff (rst)
        (stretched_o && strobe_i) |=> stretched_o);

endmodule

// File: tb/pulse_stretch_tb.sv
`timescale 1ns/1ps
module pulse_stretch_tb;
    import pstr_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strobe = 1'b0;
    logic out_reg, out_fast, out_l6, out_f5;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;

    pulse_stretch #(.LEN(4), .MODE(PSTR_REGISTERED)) u_dut (
        .clk(clk), .rst(rst), .strobe_i(strobe), .stretched_o(out_reg));
    pulse_stretch #(.LEN(4), .MODE(PSTR_LOWLAT)) u_dut_fast (
        .clk(clk), .rst(rst), .strobe_i(strobe), .stretched_o(out_fast));
    pulse_stretch #(.LEN(6), .MODE(PSTR_REGISTERED)) u_dut_l6 (
        .clk(clk), .rst(rst), .strobe_i(strobe), .stretched_o(out_l6));
    pulse_stretch #(.LEN(5), .MODE(PSTR_LOWLAT)) u_dut_f5 (
        .clk(clk), .rst(rst), .strobe_i(strobe), .stretched_o(out_f5));

    // {strobe, expected registered, expected low-latency}, one entry per cycle
    localparam int NV = 28;
    localparam logic [2:0] VEC [NV] = '{
        3'b000, 3'b101, 3'b011, 3'b011, 3'b011, 3'b010, 3'b000, 3'b000, // isolated R2 R3 R4 R5
        3'b101, 3'b011, 3'b011, 3'b111, 3'b011, 3'b011, 3'b011, 3'b010, // retrigger R6
        3'b000, 3'b101, 3'b111, 3'b111, 3'b011, 3'b011, 3'b011, 3'b010, // back-to-back R7
        3'b000, 3'b000, 3'b000, 3'b000                                  // idle R8
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // drive away from the rising edge, sample just before the next one
    task automatic step(input logic s, input logic r);
        @(negedge clk);
        strobe = s;
        rst    = r;
        #1;
    endtask

    initial begin
        // R1: reset with strobe held high is ignored
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk("R1 registered low after reset", out_reg, 1'b0);
        chk("R1 low-latency low after reset", out_fast, 1'b0);
        chk("R1 len6 low after reset", out_l6, 1'b0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i][2], 1'b0);
            chk($sformatf("R2/R3/R6/R7/R8 registered cycle %0d", i), out_reg, VEC[i][1]);
            chk($sformatf("R4/R5/R6/R7 low-latency cycle %0d", i), out_fast, VEC[i][0]);
        end

        // R3 / R5 at other lengths: count the run and its start cycle
        begin
            int hi6 = 0, hi5 = 0, first6 = -1, first5 = -1;
            for (int c = 0; c < 12; c++) begin
                step(c == 0, 1'b0);
                if (out_l6) begin hi6++; if (first6 < 0) first6 = c; end
                if (out_f5) begin hi5++; if (first5 < 0) first5 = c; end
            end
            chk("R3 len6 run length is 6", hi6 == 6, 1'b1);
            chk("R2 len6 run starts one cycle after strobe", first6 == 1, 1'b1);
            chk("R5 len5 run length is 5", hi5 == 5, 1'b1);
            chk("R4 len5 run starts in strobe cycle", first5 == 0, 1'b1);
            if (hi6 != 6) $display("  len6 high cycles=%0d", hi6);
            if (hi5 != 5) $display("  len5 high cycles=%0d", hi5);
        end

        // R9: reset in mid-pulse
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R9 registered high before reset", out_reg, 1'b1);
        step(1'b0, 1'b1);
        for (int c = 0; c < 6; c++) begin
            step(1'b0, 1'b0);
            chk($sformatf("R9 registered low after reset +%0d", c), out_reg, 1'b0);
            chk($sformatf("R9 low-latency low after reset +%0d", c), out_fast, 1'b0);
            chk($sformatf("R9 len6 low after reset +%0d", c), out_l6, 1'b0);
        end

        // R6: strobe in the last high cycle extends the run
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        chk("R6 registered still high at retrigger", out_reg, 1'b1);
        for (int c = 0; c < 4; c++) begin
            step(1'b0, 1'b0);
            chk($sformatf("R6 registered extended +%0d", c), out_reg, 1'b1);
        end
        step(1'b0, 1'b0);
        chk("R6 registered ends after extension", out_reg, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule